// File: doc/BRIEF.md
# Processor-Side Bus Ownership Arbiter

This block is the part of a processor's bus unit that hands the shared system bus to one external master, such as a DMA engine, and takes it back. The handshake uses three active-low wires. The requester pulls its request line low to ask for the bus. The arbiter answers with a grant and releases the processor's address, data and control pins, so that the requester can drive them. The requester then pulls the acknowledge line low to say it has taken the bus.

A grant is never issued while the processor has a transfer under way. A transfer is under way when its address strobe is low or when it is running a locked, indivisible operation. Once the acknowledge has been seen, the grant is removed. From then on the acknowledge alone decides how long the bus stays released: the request line no longer matters. One clock after the acknowledge goes high, the processor drives its pins again.

Every output is decoded from a single registered state, so all responses come one clock after the inputs are sampled. The requester is assumed to be synchronous to the processor clock.

Top module: `bus_own_arbiter`

## Requirements
- R1: While reset is held (synchronous, active low), the grant output is high (inactive), every pin enable is 1 (the processor drives) and `cpu_owns_bus` is 1.
- R2: In the owned state, a clock edge that samples the request low, the address strobe high and the lock input low makes the grant go low after that edge.
- R3: In the owned state, a clock edge that samples the address strobe low, or the lock input high, keeps the grant high. The grant goes low after the first edge at which both are clear while the request is still low.
- R4: While the grant is low, and for the whole time the bus is released, every bit of `addr_oe`, `data_oe` and `ctrl_oe` is 0 and `cpu_owns_bus` is 0. In every cycle all enable bits carry the same value as `cpu_owns_bus`.
- R5: An edge that samples the acknowledge low while the grant is low makes the grant go high after that edge. The pins stay released.
- R6: Once the bus is released, the request level has no effect. The pins stay released and the grant stays high until an edge samples the acknowledge high. After that edge, every enable and `cpu_owns_bus` return to 1.
- R7: An edge that samples the request high and the acknowledge high while the grant is low withdraws the grant. After that edge the grant is high and every enable is 1 again.
- R8: If the request rises in the same cycle that the acknowledge falls, the acknowledge wins: the bus goes to the released state (grant high, enables 0).
- R9: An acknowledge that arrives low while the processor owns the bus and no grant is out has no effect. The grant stays high and every enable stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in_n | input | 1 | Bus request from the external master, active low |
| gack_in_n | input | 1 | Acknowledge from the master that it has taken the bus, active low |
| cpu_as_n | input | 1 | Processor address strobe, active low; low means a transfer is under way |
| cpu_lock | input | 1 | Processor is in an indivisible operation; holds off the grant |
| grant_out_n | output | 1 | Bus grant to the master, active low |
| cpu_owns_bus | output | 1 | 1 while the processor may start bus transfers |
| addr_oe | output | ADDR_W | Per-pin output enables for the processor address pads |
| data_oe | output | DATA_W | Per-pin output enables for the processor data pads |
| ctrl_oe | output | CTRL_W | Per-pin output enables for the processor control strobes |

## Verification
The bench goes after the edges of the handshake:
- **Busy processor.** It holds the request low while the address strobe or the lock input is busy. A design that ignores the busy processor would grant in the middle of a transfer and float pins the processor is still driving.
- **Request dropped while granted.** It drops the request while the grant is out. A design that misses this would leave the bus parked with nobody driving it.
- **Request and acknowledge change together.** It raises the request in the same cycle the acknowledge falls. Giving the withdrawal priority would take the bus back from a master that has just started driving it.
- **Request toggled while released.** It toggles the request during the released period. It also sends a stray acknowledge while the processor owns the bus. A design that reacts to either would reclaim the bus early, which causes contention, or would float the pins when nobody asked for them.

// File: rtl/bus_own_arb_pkg.sv
// Package: shared state encoding for the bus ownership arbiter.
// Assumes: only one external master, so there are three states.
package bus_own_arb_pkg;

    typedef enum logic [1:0] {
        ST_OWNED    = 2'b00,   // processor drives the bus
        ST_GRANTED  = 2'b01,   // grant out, waiting for acknowledge
        ST_RELEASED = 2'b10    // master has taken the bus
    } own_state_t;

endpackage

// File: rtl/bus_own_idle.sv
// Module: bus_own_idle
// Decides whether the processor side is quiet enough to hand over the bus.
// Assumes: cpu_as_n and cpu_lock are synchronous to clk.
module bus_own_idle (
    input  logic cpu_as_n,
    input  logic cpu_lock,
    output logic cpu_quiet
);

    // Quiet only with no strobe and no locked sequence.
    always_comb begin
        cpu_quiet = cpu_as_n && !cpu_lock;
    end

endmodule

// File: rtl/bus_own_fsm.sv
// Module: bus_own_fsm
// Ownership state machine for the request, grant and acknowledge handshake.
// Assumes: all inputs synchronous to clk; a single requester.
module bus_own_fsm
    import bus_own_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n,
    input  logic       gack_n,
    input  logic       cpu_quiet,
    output own_state_t state_q,
    output logic       grant_n
);

    own_state_t state_d;

    // Next-state decision for each ownership phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OWNED: begin
                if (!req_n && cpu_quiet) state_d = ST_GRANTED;
            end
            ST_GRANTED: begin
                if (!gack_n)    state_d = ST_RELEASED;
                else if (req_n) state_d = ST_OWNED;
            end
            ST_RELEASED: begin
                if (gack_n) state_d = ST_OWNED;
            end
            default: state_d = ST_OWNED;
        endcase
    end

    // State register with synchronous reset to the owned state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OWNED;
        else        state_q <= state_d;
    end

    // Grant is low only while waiting for the acknowledge.
    always_comb begin
        grant_n = (state_q != ST_GRANTED);
    end

    // R2
    grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && !req_n && cpu_quiet) |=> !grant_n);

    // R3
    busy_holds_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && !cpu_quiet) |=> grant_n);

    // R5
    ack_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n && !gack_n) |=> (grant_n && state_q == ST_RELEASED));

    // R7
    withdraw_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n && req_n && gack_n) |=> (grant_n && state_q == ST_OWNED));

    // R9
    stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && req_n && !gack_n) |=> (state_q == ST_OWNED));

endmodule

// File: rtl/bus_own_drive.sv
// Module: bus_own_drive
// Turns the ownership state into a vector of per-pin output enables.
// Assumes: the pads drive when an enable bit is 1.
module bus_own_drive
    import bus_own_arb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  own_state_t        state_q,
    output logic [WIDTH-1:0]  pin_oe
);

    logic drive_on;

    // Pins are driven only in the owned state.
    always_comb begin
        drive_on = (state_q == ST_OWNED);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // One enable per pad.
        always_comb begin
            pin_oe[i] = drive_on;
        end
    end

endmodule

// File: rtl/bus_own_arbiter.sv
// Module: bus_own_arbiter (top)
// Processor-side arbiter that hands the bus to one external master and
// floats the processor's address, data and control pads while it owns it.
// Assumes: a requester synchronous to clk that drives the bus only after
// it has acknowledged.
module bus_own_arbiter
    import bus_own_arb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in_n,
    input  logic              gack_in_n,
    input  logic              cpu_as_n,
    input  logic              cpu_lock,
    output logic              grant_out_n,
    output logic              cpu_owns_bus,
    output logic [ADDR_W-1:0] addr_oe,
    output logic [DATA_W-1:0] data_oe,
    output logic [CTRL_W-1:0] ctrl_oe
);

    localparam int ALL_W = ADDR_W + DATA_W + CTRL_W;

    logic       quiet;
    own_state_t st;

    bus_own_idle u_idle (
        .cpu_as_n  (cpu_as_n),
        .cpu_lock  (cpu_lock),
        .cpu_quiet (quiet)
    );

    bus_own_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_in_n),
        .gack_n    (gack_in_n),
        .cpu_quiet (quiet),
        .state_q   (st),
        .grant_n   (grant_out_n)
    );

    bus_own_drive #(.WIDTH(ADDR_W)) u_addr_drv (.state_q(st), .pin_oe(addr_oe));
    bus_own_drive #(.WIDTH(DATA_W)) u_data_drv (.state_q(st), .pin_oe(data_oe));
    bus_own_drive #(.WIDTH(CTRL_W)) u_ctrl_drv (.state_q(st), .pin_oe(ctrl_oe));

    // Processor may start transfers only in the owned state.
    always_comb begin
        cpu_owns_bus = (st == ST_OWNED);
    end

    // R4
    float_while_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_out_n |-> ({addr_oe, data_oe, ctrl_oe} == '0 && !cpu_owns_bus));

    // R4
    enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({addr_oe, data_oe, ctrl_oe}) == (cpu_owns_bus ? ALL_W : 0)));

    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_out_n && !cpu_owns_bus && !gack_in_n) |=> (!cpu_owns_bus && grant_out_n));

    // R6
    reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_out_n && !cpu_owns_bus && gack_in_n) |=> cpu_owns_bus);

endmodule

// File: tb/test_bus_own_arbiter.sv
module test_bus_own_arbiter;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 6;

    // Bench-side phase codes: 0 owned, 1 granted, 2 released.
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, gack_n = 1'b1, as_n = 1'b1, lock = 1'b0;
    logic grant_n, owns;
    logic [AW-1:0] a_oe;
    logic [DW-1:0] d_oe;
    logic [CW-1:0] c_oe;

    int checks = 0;
    int errors = 0;
    int exp_ph = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    bus_own_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW)) i_bus_own_arbiter (
        .clk(clk), .rst_n(rst_n), .req_in_n(req_n), .gack_in_n(gack_n),
        .cpu_as_n(as_n), .cpu_lock(lock), .grant_out_n(grant_n),
        .cpu_owns_bus(owns), .addr_oe(a_oe), .data_oe(d_oe), .ctrl_oe(c_oe)
    );

    // Next phase, as the requirements define it.
    function automatic int next_ph(int ph, logic rq, logic ak, logic a, logic lk);
        if (ph == 0) return (!rq && a && !lk) ? 1 : 0;
        if (ph == 1) return (!ak) ? 2 : (rq ? 0 : 1);
        return ak ? 0 : 2;
    endfunction

    // Requirement that a given transition exercises.
    function automatic string tag_of(int ph, logic rq, logic ak, logic a, logic lk);
        if (ph == 0) begin
            if (!rq && (!a || lk)) return "R3";
            if (!rq) return "R2";
            if (!ak) return "R9";
            return "R1";
        end
        if (ph == 1) begin
            if (!ak && rq) return "R8";
            if (!ak) return "R5";
            return rq ? "R7" : "R4";
        end
        return "R6";
    endfunction

    task automatic check_out();
        logic exp_g, exp_own;
        logic [AW+DW+CW-1:0] exp_oe, got_oe;
        exp_g   = (exp_ph != 1);
        exp_own = (exp_ph == 0);
        exp_oe  = exp_own ? '1 : '0;
        got_oe  = {a_oe, d_oe, c_oe};
        checks++;
        if (grant_n !== exp_g || owns !== exp_own || got_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s: got grant_n=%b owns=%b oe=%h, expected grant_n=%b owns=%b oe=%h",
                     cur_tag, grant_n, owns, got_oe, exp_g, exp_own, exp_oe);
        end
    endtask

    // Drive one cycle at a falling edge; check one cycle later.
    task automatic step(logic rq, logic ak, logic a, logic lk);
        req_n = rq; gack_n = ak; as_n = a; lock = lk;
        cur_tag = tag_of(exp_ph, rq, ak, a, lk);
        exp_ph  = next_ph(exp_ph, rq, ak, a, lk);
        @(negedge clk);
        check_out();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got no end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7213));
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        exp_ph = 0;
        check_out();
        rst_n = 1'b1;
        // R3: strobe busy, then lock busy, then both clear.
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 1, 1);
        // R2: grant appears one clock after the quiet edge.
        step(0, 1, 1, 0);
        // R4: waiting, pins floated.
        step(0, 1, 1, 0);
        // R5: acknowledge.
        step(0, 0, 1, 0);
        // R6: request toggles while released; no effect.
        step(1, 0, 1, 0);
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        step(1, 1, 1, 0);
        // R7: withdraw before acknowledge.
        step(0, 1, 1, 0);
        step(1, 1, 1, 0);
        // R8: request rises as acknowledge falls.
        step(0, 1, 1, 0);
        step(1, 0, 1, 0);
        step(1, 1, 1, 0);
        // R9: stray acknowledge while owned.
        step(1, 0, 1, 0);
        step(1, 0, 0, 1);
        // Random phase, mixed patterns.
        for (int i = 0; i < 3000; i++) begin
            logic rq, ak, a, lk;
            rq = ($urandom % 4) != 0;
            rq = ~rq | (($urandom % 3) == 0);
            ak = ($urandom % 3) != 0;
            a  = ($urandom % 4) != 0;
            lk = ($urandom % 6) == 0;
            step(rq, ak, a, lk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule